// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block holds the hazard logic of a five-stage in-order pipeline whose register file has 32 registers of 16 bits. For each of the up to three source operands of the instruction in the execute stage, it works out whether the value must be taken from the register file or bypassed from a younger result. That result is held either in the memory-access stage or in the write-back stage. The conditional store instructions read a third register, a validity word named in the destination field, so the forwarding and the interlock both handle three operands and not two.

The block also decides when the front of the pipeline must wait. One case is an instruction in decode that needs a register which a cache load now in execute is going to write. In that case the program counter and the fetch/decode register hold, and a bubble with no register write goes into the decode/execute register. The other case is the cache controller reporting that it is busy with the backing memory. Then the back of the pipeline holds for as long as the busy flag stays high, however many cycles the miss takes. The unit has no state of its own. The clock and reset feed only its embedded checks.

Top module: `hazard_unit`

## Requirements
- R1: Each forward select is 2 bits wide and coded as 00 for the register file, 01 for the memory-access stage and 10 for the write-back stage. The code 11 never appears.
- R2: An execute operand that is in use and equals the destination of a memory-access stage instruction with its write enable set gets select 01.
- R3: When the memory-access and write-back stages both write the register an operand needs, the memory-access stage wins (01).
- R4: An operand that is in use and matches only the write-back stage destination with its write enable set gets select 10.
- R5: Register 0 is forwarded and interlocked like any other register. There is no special case for index 0.
- R6: An operand that is not in use gets select 00 whatever the stage destinations are. The third (Rd) operand is in use only when the conditional-store flag of its stage is set.
- R7: When the execute stage holds a cache load and its destination equals any in-use source of the decode instruction, hold_front and idex_nop are 1 and hold_back is 0.
- R8: While cache_busy is 1, hold_front and hold_back are 1 and idex_nop is 0, for every cycle of the busy period.
- R9: With cache_busy at 0 and no load in execute, as for receive, add, subtract and checksum-add, all three stall outputs are 0.
- R10: A decode source that is not in use, including Rd of a non-store instruction, never causes a load-use stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| id_rs | input | 5 | Decode-stage first source register |
| id_rt | input | 5 | Decode-stage second source register |
| id_rd | input | 5 | Decode-stage Rd field |
| id_use_rs | input | 1 | Decode instruction reads Rs |
| id_use_rt | input | 1 | Decode instruction reads Rt |
| id_cstore | input | 1 | Decode instruction is a conditional store (reads Rd) |
| ex_rs | input | 5 | Execute-stage first source register |
| ex_rt | input | 5 | Execute-stage second source register |
| ex_rd | input | 5 | Execute-stage Rd field |
| ex_use_rs | input | 1 | Execute instruction reads Rs |
| ex_use_rt | input | 1 | Execute instruction reads Rt |
| ex_cstore | input | 1 | Execute instruction is a conditional store (reads Rd) |
| ex_load | input | 1 | Execute instruction is a cache load |
| ex_dst | input | 5 | Destination of the execute instruction |
| mem_we | input | 1 | Memory-access stage writes a register |
| mem_dst | input | 5 | Memory-access stage destination |
| wb_we | input | 1 | Write-back stage writes a register |
| wb_dst | input | 5 | Write-back stage destination |
| cache_busy | input | 1 | Cache controller is moving data to or from the backing memory |
| fwd_rs | output | 2 | Select for the Rs operand |
| fwd_rt | output | 2 | Select for the Rt operand |
| fwd_rd | output | 2 | Select for the Rd operand |
| hold_front | output | 1 | Hold the program counter and the fetch/decode register |
| hold_back | output | 1 | Hold the decode/execute and execute/memory registers |
| idex_nop | output | 1 | Load a bubble with no register write into decode/execute |

## Verification
The bench targets the case where both later stages write the same register. A design with the priority reversed would hand an operand a stale value from the write-back stage. It drives register 0 as a source and as a destination, where a design that filtered out index 0 would select the register file. It places the Rd field on a non-store instruction: a design that always compared Rd would stall or bypass for nothing. It also holds cache_busy high for several cycles while a load-use pattern sits in place. There, a design that bubbled instead of holding would drop the instruction waiting in decode/execute.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [AW-1:0] id_rd,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_cstore,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_use_rs,
  input  logic          ex_use_rt,
  input  logic          ex_cstore,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_dst,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_dst,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_dst,
  input  logic          cache_busy,
  output logic [1:0]    fwd_rs,
  output logic [1:0]    fwd_rt,
  output logic [1:0]    fwd_rd,
  output logic          hold_front,
  output logic          hold_back,
  output logic          idex_nop
);

  localparam int NOPS = 3;

  logic [NOPS-1:0][AW-1:0] ex_src, id_src;
  logic [NOPS-1:0]         ex_need, id_need, id_hit;
  logic [NOPS-1:0][1:0]    sel;
  logic                    load_use;

  assign ex_src  = {ex_rd, ex_rt, ex_rs};
  assign ex_need = {ex_cstore, ex_use_rt, ex_use_rs};
  assign id_src  = {id_rd, id_rt, id_rs};
  assign id_need = {id_cstore, id_use_rt, id_use_rs};

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic from_mem, from_wb;
    assign from_mem  = ex_need[k] && mem_we && (mem_dst == ex_src[k]);
    assign from_wb   = ex_need[k] && wb_we  && (wb_dst  == ex_src[k]);
    assign sel[k]    = from_mem ? 2'b01 : (from_wb ? 2'b10 : 2'b00);
    assign id_hit[k] = id_need[k] && (ex_dst == id_src[k]);

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) sel[k] != 2'b11); // R1
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !ex_need[k] |-> sel[k] == 2'b00); // R6
    AST_WB_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (sel[k] == 2'b10) |-> !(mem_we && mem_dst == ex_src[k])); // R3
  end

  assign fwd_rs = sel[0];
  assign fwd_rt = sel[1];
  assign fwd_rd = sel[2];

  assign load_use   = ex_load && (|id_hit);
  assign hold_back  = cache_busy;
  assign hold_front = cache_busy | load_use;
  assign idex_nop   = load_use & ~cache_busy;

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) cache_busy |-> (hold_front && hold_back)); // R8
  AST_BUSY_NO_NOP: assert property (@(posedge clk) disable iff (!rst_n) hold_back |-> !idex_nop); // R8
  AST_NOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) idex_nop |-> (hold_front && !hold_back)); // R7
  AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) (!ex_load && !cache_busy) |-> !(hold_front || idex_nop)); // R9

endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  logic clk = 0, rst_n = 0;
  logic [4:0] id_rs, id_rt, id_rd, ex_rs, ex_rt, ex_rd, ex_dst, mem_dst, wb_dst;
  logic id_use_rs, id_use_rt, id_cstore, ex_use_rs, ex_use_rt, ex_cstore, ex_load;
  logic mem_we, wb_we, cache_busy;
  logic [1:0] fwd_rs, fwd_rt, fwd_rd;
  logic hold_front, hold_back, idex_nop;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hazard_unit i_hazard_unit (.*);

  function automatic logic [1:0] exp_fwd(logic [4:0] s, logic u);
    if (u && mem_we && mem_dst == s) return 2'b01;
    if (u && wb_we && wb_dst == s) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_lu();
    return ex_load && ((id_use_rs && ex_dst == id_rs) || (id_use_rt && ex_dst == id_rt) ||
                       (id_cstore && ex_dst == id_rd));
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear();
    {id_rs, id_rt, id_rd, ex_rs, ex_rt, ex_rd, ex_dst, mem_dst, wb_dst} = '0;
    {id_use_rs, id_use_rt, id_cstore, ex_use_rs, ex_use_rt, ex_cstore, ex_load} = '0;
    {mem_we, wb_we, cache_busy} = '0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic check_all(string ftag, string stag);
    chk({ftag, " rs"}, {2'b0, fwd_rs}, {2'b0, exp_fwd(ex_rs, ex_use_rs)});
    chk({ftag, " rt"}, {2'b0, fwd_rt}, {2'b0, exp_fwd(ex_rt, ex_use_rt)});
    chk({ftag, " rd"}, {2'b0, fwd_rd}, {2'b0, exp_fwd(ex_rd, ex_cstore)});
    if (cache_busy) chk(stag, {1'b0, hold_front, hold_back, idex_nop}, 4'b0110);
    else chk(stag, {1'b0, hold_front, hold_back, idex_nop}, {1'b0, exp_lu(), 1'b0, exp_lu()});
  endtask

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R9 reset idle", {fwd_rs, fwd_rt}, 4'h0);
    chk("R9 reset stall", {1'b0, hold_front, hold_back, idex_nop}, 4'h0);

    ex_use_rs = 1; ex_rs = 5'd7; mem_we = 1; mem_dst = 5'd7; settle();
    chk("R2 mem fwd rs", {2'b0, fwd_rs}, 4'h1);

    wb_we = 1; wb_dst = 5'd7; settle();
    chk("R3 mem over wb", {2'b0, fwd_rs}, 4'h1);

    mem_dst = 5'd8; settle();
    chk("R4 wb fwd rs", {2'b0, fwd_rs}, 4'h2);
    chk("R1 legal code", {2'b0, fwd_rs}, 4'h2);

    clear(); ex_use_rt = 1; ex_rt = 5'd0; mem_we = 1; mem_dst = 5'd0; settle();
    chk("R5 reg0 fwd", {2'b0, fwd_rt}, 4'h1);

    clear(); ex_rd = 5'd4; wb_we = 1; wb_dst = 5'd4; mem_we = 1; mem_dst = 5'd4; settle();
    chk("R6 rd unused", {2'b0, fwd_rd}, 4'h0);
    ex_cstore = 1; settle();
    chk("R6 rd store", {2'b0, fwd_rd}, 4'h1);

    clear(); ex_load = 1; ex_dst = 5'd9; id_use_rt = 1; id_rt = 5'd9; settle();
    chk("R7 load-use", {1'b0, hold_front, hold_back, idex_nop}, 4'b0101);

    clear(); ex_load = 1; ex_dst = 5'd0; id_cstore = 1; id_rd = 5'd0; settle();
    chk("R5 reg0 interlock", {1'b0, hold_front, hold_back, idex_nop}, 4'b0101);

    id_cstore = 0; settle();
    chk("R10 rd not read", {1'b0, hold_front, hold_back, idex_nop}, 4'b0000);

    clear(); ex_dst = 5'd3; id_use_rs = 1; id_rs = 5'd3; settle();
    chk("R9 alu no stall", {1'b0, hold_front, hold_back, idex_nop}, 4'b0000);

    ex_load = 1; cache_busy = 1;
    for (int c = 0; c < 5; c++) begin
      settle();
      chk("R8 busy hold", {1'b0, hold_front, hold_back, idex_nop}, 4'b0110);
    end
    cache_busy = 0; settle();
    chk("R7 after busy", {1'b0, hold_front, hold_back, idex_nop}, 4'b0101);

    void'($urandom(32'd2718));
    for (int n = 0; n < 400; n++) begin
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3)); id_rd = 5'($urandom_range(0, 3));
      ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3)); ex_rd = 5'($urandom_range(0, 3));
      ex_dst = 5'($urandom_range(0, 3)); mem_dst = 5'($urandom_range(0, 3)); wb_dst = 5'($urandom_range(0, 3));
      {id_use_rs, id_use_rt, id_cstore, ex_use_rs, ex_use_rt, ex_cstore} = 6'($urandom);
      ex_load = 1'($urandom); mem_we = 1'($urandom); wb_we = 1'($urandom);
      cache_busy = ($urandom_range(0, 7) == 0);
      settle();
      check_all("R2 random fwd", "R7 random stall");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule